// File: doc/BRIEF.md
# Fractional Audio Bit-Clock Divider

This block derives an audio bit clock from a fast reference clock. The divide ratio is an integer count plus a fraction in 1/512 steps, and a divide-by-two stage follows it. Each time a divide period ends, the block emits a one-cycle enable pulse (`bclk_tick`). The bit clock output (`bclk`) toggles on every pulse. The bit clock therefore runs at f_ref / (2 × (N + F/512)), and its duty cycle averages 50%.

Software programs two registers through a simple write port. The integer register holds N. The fraction register holds F and the run enable. A 9-bit phase accumulator adds F once per divide period. When the addition carries past 511, that period gains one reference cycle. Over 512 periods the lengths therefore average exactly N + F/512. When the interface acts as a clock slave, the `slave_mode` input silences the divider, so no bit clock is driven.

Top module: `bclk_divider`

## Requirements
- R1: A write with `wr_sel`=0 loads N from `wr_data[9:0]`. A write with `wr_sel`=1 loads F from `wr_data[8:0]` and the run enable from `wr_data[31]`. All other data bits are ignored.
- R2: With F=0 and N≥2, `bclk_tick` pulses for one cycle every N reference cycles. The first pulse appears N cycles after the clock edge that captures the enabling write.
- R3: Before each divide period, the phase accumulator is loaded with (acc + F) mod 512, starting from 0 on enable. A period whose addition carries lasts N+1 cycles, and any other period lasts N. Any 512 consecutive periods therefore span exactly 512·N + F cycles.
- R4: An N value of 0 or 1 is treated as 2, so a divide period is never shorter than 2 cycles.
- R5: `bclk` inverts at the clock edge that ends each `bclk_tick` cycle and is otherwise steady. A full bit-clock cycle therefore spans two divide periods.
- R6: Clearing the run enable stops `bclk_tick` and drives `bclk` low from the next cycle. It also clears the accumulator, so a later enable restarts the period sequence from acc = 0.
- R7: While `slave_mode` is 1, the divider behaves as if disabled: no pulses are produced and `bclk` is held low.
- R8: A new N or F written while the divider runs takes effect at the next period boundary. The period in progress, and one loaded on the same edge as the write, keep the old value.
- R9: After reset, `bclk` and `bclk_tick` are 0, the divider is disabled, and N and F are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 integer, 1 fraction and enable |
| wr_data | input | 32 | Register write data |
| slave_mode | input | 1 | 1 when the bit clock is supplied externally; stops the divider |
| bclk_tick | output | 1 | One-cycle pulse at the end of each divide period |
| bclk | output | 1 | Divided bit clock, toggled on each pulse |

## Verification
The main patterns for the divide ratio are:
- A pure integer ratio, which gives constant periods.
- A mid-range fraction, whose carries fall at irregular points. This separates a correct accumulator from one that carries late or wraps wrongly.
- A fraction of 511, which makes almost every period long.
- Ratios below 2, which exercise the clamp.

Every period length is compared against an independent model of the accumulator. The first period after each enable is included in that comparison, so a missing accumulator clear shows up as a wrong length. The rest is checked directly:
- A 512-period window measures the long-run average.
- A write made mid-run separates a change taken at the period boundary from one taken immediately.
- Idle windows with the enable cleared and with slave mode set confirm that the clock stays silent.

// File: rtl/bclk_div_pkg.sv
package bclk_div_pkg;

  // Length in reference cycles of one divide period: the clamped integer
  // part plus one when the phase accumulator carries.
  function automatic int unsigned period_len(input int unsigned n,
                                             input bit carry,
                                             input int unsigned min_div);
    int unsigned base;
    base = (n < min_div) ? min_div : n;
    return base + (carry ? 1 : 0);
  endfunction

  // Unwrapped phase sum; the bit above the fraction width is the carry.
  function automatic int unsigned phase_sum(input int unsigned acc,
                                            input int unsigned frac);
    return acc + frac;
  endfunction

endpackage

// File: rtl/bclk_div_regs.sv
module bclk_div_regs #(
  parameter int DATA_W = 32,
  parameter int INT_W  = 10,
  parameter int FRAC_W = 9,
  parameter int EN_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              slave_mode,
  output logic [INT_W-1:0]  div_int,
  output logic [FRAC_W-1:0] div_frac,
  output logic              run
);
  logic enable_q;
  wire  unused_wr_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_int  <= '0;
      div_frac <= '0;
      enable_q <= 1'b0;
    end else if (wr_en) begin
      if (!wr_sel) begin
        div_int <= wr_data[INT_W-1:0];
      end else begin
        div_frac <= wr_data[FRAC_W-1:0];
        enable_q <= wr_data[EN_BIT];
      end
    end
  end

  assign run = enable_q & ~slave_mode;

  // R1: registers only change on a write
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(div_int) && $stable(div_frac)));

  // R1: integer field lands from its own bit slice
  a_r1_int_field: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (div_int == $past(wr_data[INT_W-1:0])));

endmodule

// File: rtl/bclk_div_phase.sv
module bclk_div_phase #(
  parameter int FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              carry
);
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;

  always_comb begin
    sum   = (FRAC_W+1)'(bclk_div_pkg::phase_sum(32'(acc), 32'(div_frac)));
    carry = sum[FRAC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (!run)   acc <= '0;
    else if (load)   acc <= sum[FRAC_W-1:0];
  end

  // R6: disabled divider holds the accumulator at zero
  a_r6_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (acc == '0));

  // R3: accumulator advances only at a period boundary
  a_r3_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> $stable(acc));

  // R3: a carrying step wraps the phase below its old value
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && load && carry) |=> (acc < $past(acc)));

  // R3: a non-carrying step never moves the phase backwards
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && load && !carry) |=> (acc >= $past(acc)));

endmodule

// File: rtl/bclk_div_timer.sv
module bclk_div_timer #(
  parameter int INT_W   = 10,
  parameter int MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [INT_W-1:0] div_int,
  input  logic             carry,
  output logic             load,
  output logic             tick,
  output logic             bclk
);
  localparam int CNT_W = INT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;
  logic             started;
  logic             at_end;

  always_comb begin
    len    = CNT_W'(bclk_div_pkg::period_len(32'(div_int), carry, MIN_DIV));
    at_end = (cnt == '0);
  end

  assign tick = run & started & at_end;
  assign load = run & (~started | at_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      started <= 1'b0;
      bclk    <= 1'b0;
    end else if (!run) begin
      cnt     <= '0;
      started <= 1'b0;
      bclk    <= 1'b0;
    end else begin
      if (load) begin
        cnt     <= len - CNT_W'(1);
        started <= 1'b1;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
      if (tick) bclk <= ~bclk;
    end
  end

  // R4: every loaded period spans at least two cycles
  a_r4_min_period: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt != '0));

  // R5: each pulse flips the bit clock
  a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (bclk != $past(bclk)));

  // R5: bit clock steady between pulses while running
  a_r5_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(bclk));

  // R6/R7: stopped divider forces the clock low and idles the counter
  a_r6_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!bclk && !tick));

endmodule

// File: rtl/bclk_divider.sv
module bclk_divider #(
  parameter int DATA_W  = 32,
  parameter int INT_W   = 10,
  parameter int FRAC_W  = 9,
  parameter int EN_BIT  = 31,
  parameter int MIN_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              slave_mode,
  output logic              bclk_tick,
  output logic              bclk
);
  logic [INT_W-1:0]  div_int;
  logic [FRAC_W-1:0] div_frac;
  logic              run;
  logic              load;
  logic              carry;

  bclk_div_regs #(
    .DATA_W(DATA_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .EN_BIT(EN_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .slave_mode(slave_mode),
    .div_int(div_int), .div_frac(div_frac), .run(run)
  );

  bclk_div_phase #(.FRAC_W(FRAC_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load),
    .div_frac(div_frac), .carry(carry)
  );

  bclk_div_timer #(.INT_W(INT_W), .MIN_DIV(MIN_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .div_int(div_int),
    .carry(carry), .load(load), .tick(bclk_tick), .bclk(bclk)
  );

  // R7: slave mode never lets a pulse out
  a_r7_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> !bclk_tick);

endmodule

// File: tb/bclk_divider_test.sv
module bclk_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        slave_mode = 1'b0;
  logic        bclk_tick;
  logic        bclk;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  longint      cyc = 0;
  bit          done = 1'b0;

  int unsigned exp_q[$];
  bit          mon_active = 1'b0;
  longint      mon_prev = 0;
  string       cur_req = "R2";
  bit          tog_pend = 1'b0;
  logic        tog_prev = 1'b0;

  bclk_divider uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .slave_mode(slave_mode),
    .bclk_tick(bclk_tick), .bclk(bclk)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Monitor: period lengths against the scoreboard, bit-clock flips (R5)
  always @(negedge clk) begin
    if (tog_pend) begin
      chk(bclk == ~tog_prev, "R5", bclk, ~tog_prev);
      tog_pend = 1'b0;
    end
    if (mon_active && bclk_tick) begin
      if (exp_q.size() > 0) begin
        int unsigned e;
        e = exp_q.pop_front();
        chk((cyc - mon_prev) == longint'(e), cur_req, cyc - mon_prev, e);
      end
      mon_prev = cyc;
      tog_prev = bclk;
      tog_pend = 1'b1;
    end
  end

  task automatic reg_write(input bit sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!bclk_tick);
  endtask

  // Independent model of the period sequence
  task automatic push_periods(input int unsigned n, input int unsigned f,
                              input int count);
    int unsigned acc = 0;
    for (int i = 0; i < count; i++) begin
      int unsigned len;
      acc = acc + f;
      len = (n < 2) ? 2 : n;
      if (acc >= 512) begin
        acc = acc - 512;
        len = len + 1;
      end
      exp_q.push_back(len);
    end
  endtask

  task automatic run_cfg(input string req, input logic [31:0] int_word,
                         input logic [31:0] frac_word, input int unsigned n,
                         input int unsigned f, input int count);
    reg_write(1'b1, 32'h0);
    repeat (3) @(negedge clk);
    cur_req = req;
    reg_write(1'b0, int_word);
    push_periods(n, f, count);
    reg_write(1'b1, frac_word);
    mon_prev = cyc;
    mon_active = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    mon_active = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int tcount;
    longint t0, t1, t2;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(bclk == 1'b0, "R9", bclk, 0);
    chk(bclk_tick == 1'b0, "R9", bclk_tick, 0);
    rst_n = 1'b1;
    tcount = 0;
    repeat (20) begin @(negedge clk); if (bclk_tick || bclk) tcount++; end
    chk(tcount == 0, "R9", tcount, 0);

    // R2: integer ratio
    run_cfg("R2", 32'd4, 32'h8000_0000, 4, 0, 20);
    // R3: fractional patterns
    run_cfg("R3", 32'd4, 32'h8000_0000 | 32'd300, 4, 300, 40);
    run_cfg("R3", 32'd7, 32'h8000_0000 | 32'd511, 7, 511, 30);
    // R4: clamp below 2
    run_cfg("R4", 32'd1, 32'h8000_0000, 1, 0, 10);
    run_cfg("R4", 32'd0, 32'h8000_0000 | 32'd256, 0, 256, 12);
    // R1: unrelated data bits set around the fields
    run_cfg("R1", 32'hFFFF_FC05, 32'hFFFF_FE03, 5, 3, 20);

    // R6: disable while running, clock goes low and stays quiet
    reg_write(1'b1, 32'h0);
    @(negedge clk);
    chk(bclk == 1'b0, "R6", bclk, 0);
    tcount = 0;
    repeat (30) begin @(negedge clk); if (bclk_tick || bclk) tcount++; end
    chk(tcount == 0, "R6", tcount, 0);
    // R6: re-enable restarts from a cleared accumulator (first period checked)
    run_cfg("R6", 32'd4, 32'h8000_0000 | 32'd300, 4, 300, 6);

    // R7: slave mode silences an enabled divider
    slave_mode = 1'b1;
    repeat (2) @(negedge clk);
    tcount = 0;
    repeat (40) begin @(negedge clk); if (bclk_tick || bclk) tcount++; end
    chk(tcount == 0, "R7", tcount, 0);
    slave_mode = 1'b0;

    // R8: mid-run change applies at the next boundary
    reg_write(1'b1, 32'h0);
    reg_write(1'b0, 32'd5);
    reg_write(1'b1, 32'h8000_0000);
    wait_tick();
    wait_tick();
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'd9;
    t0 = cyc;
    @(negedge clk);
    wr_en = 1'b0;
    wait_tick(); t1 = cyc;
    wait_tick(); t2 = cyc;
    chk((t1 - t0) == 5, "R8", t1 - t0, 5);
    chk((t2 - t1) == 9, "R8", t2 - t1, 9);

    // R3: 512 consecutive periods span 512*N + F cycles
    reg_write(1'b1, 32'h0);
    reg_write(1'b0, 32'd3);
    reg_write(1'b1, 32'h8000_0000 | 32'd5);
    wait_tick(); t0 = cyc;
    for (int i = 0; i < 512; i++) wait_tick();
    t1 = cyc;
    chk((t1 - t0) == 1541, "R3", t1 - t0, 1541);
    reg_write(1'b1, 32'h0);
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule